// File: doc/BRIEF.md
# SDRAM DQM and Clock-Suspend Pipeline

This block is the data-path timing stage that sits between a memory controller's command sequencer and the SDRAM data pins. Each cycle the host says whether a read beat or a write beat is issued, whether the byte mask is raised, and whether the clock should be suspended. The block turns these requests into the clock-enable level for the memory, the DQ drive enable and mask strobe for writes, and a strobe that marks the cycle in which returning read data is live. It also keeps the position within the current burst.

Reads and writes see the mask with different delays. A write beat is masked in the cycle it is issued. A read slot is blanked by a mask raised two active cycles earlier, so the mask history passes through a two-stage delay line. A suspend request drops the clock-enable one cycle later. While the clock-enable is low, every stage stands still: the read-latency line, the mask delay line, the write drive and mask levels and the burst counter all hold, and the interrupted read or write is stretched by the number of suspended cycles.

Top module: `sdram_mask_suspend`

## Requirements
- R1: `cke_out` in each cycle is the inverse of `susp_req` from the previous cycle, so entering and leaving suspend each take one cycle. A cycle with `cke_out` high is active and a cycle with it low is frozen.
- R2: A read beat issued in an active cycle t raises `rd_valid` in cycle t+CAS_LAT when no frozen cycle falls between them and the read slot is not blanked.
- R3: `dqm_req` high in an active cycle blanks the read slot that is due two active cycles later, and `rd_valid` stays low in that slot.
- R4: In an active cycle `dq_oe` equals `wr_beat` and `wr_mask` equals `wr_beat AND dqm_req`, both in the same cycle, so mask latency is zero for writes.
- R5: While frozen, `rd_valid` is low and no pending read is lost. Each frozen cycle delays every pending read slot by one cycle, and the mask history that blanks those slots is delayed with them.
- R6: While frozen, `dq_oe` and `wr_mask` repeat the values of the last active cycle, which stretches the interrupted write beat whatever the inputs do.
- R7: `burst_pos` advances by one, wrapping from BURST_LEN-1 to 0, after each active cycle that carries a read or write beat. It holds otherwise.
- R8: Read beats, write beats and mask requests presented in frozen cycles have no effect: they give no read slot, no drive, no mask and no counter step, and they do not enter the mask history.
- R9: While reset is asserted, `cke_out` is 1, `burst_pos` is 0 and `rd_valid` is 0, even when `susp_req` or `rd_beat` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_beat | input | 1 | Read beat issued this cycle |
| wr_beat | input | 1 | Write beat issued this cycle |
| dqm_req | input | 1 | Byte-mask request for this cycle |
| susp_req | input | 1 | Request to suspend the memory clock |
| cke_out | output | 1 | Clock-enable level sent to the memory |
| dq_oe | output | 1 | Controller drives DQ with write data |
| wr_mask | output | 1 | Mask strobe for the current write beat |
| rd_valid | output | 1 | Read data on DQ is live this cycle |
| burst_pos | output | $clog2(BURST_LEN) | Beat position within the burst |

## Verification
Back-to-back read bursts are run clean and with masks on chosen beats. This separates the two-cycle read blanking from a same-cycle blanking and shows which slot each mask hits. The same read patterns are then cut by suspend windows of one and three cycles, with masks placed before and inside the window. These show whether the read line and the mask history freeze together and whether frozen inputs leak in. Writes are masked and suspended mid-beat to tell a stretched beat from a fresh one. Mixed read and write bursts longer than BURST_LEN exercise the counter wrap.

// File: rtl/sdmp_pkg.sv
package sdmp_pkg;

  // Read-side mask latency in active cycles.
  localparam int unsigned DQM_RD_LAT = 2;

  // Next beat position within a burst of len beats.
  function automatic int unsigned wrap_inc(input int unsigned pos, input int unsigned len);
    return (pos + 1 >= len) ? 0 : pos + 1;
  endfunction

  // A read slot is live when data is due, it is not blanked and the clock runs.
  function automatic logic slot_live(input logic data_due, input logic blanked, input logic clk_on);
    return data_due & ~blanked & clk_on;
  endfunction

  // Write-side mask: zero latency, only on a write beat.
  function automatic logic wr_masked(input logic beat, input logic dqm);
    return beat & dqm;
  endfunction

endpackage

// File: rtl/sdmp_cke_ctrl.sv
module sdmp_cke_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic susp_req,
  output logic cke_q,
  output logic active
);

  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      live_q <= 1'b0;
    end else begin
      cke_q  <= ~susp_req;
      live_q <= 1'b1;
    end
  end

  assign active = cke_q;

  // One-cycle entry and exit latency of suspend.
  assert_cke_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (cke_q == !$past(susp_req)));

endmodule

// File: rtl/sdmp_hold_shift.sv
module sdmp_hold_shift #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] line;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   line <= '0;
        else if (adv) line <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   line <= '0;
        else if (adv) line <= {line[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign dout = line[DEPTH-1];

  // Every stage stands still in a frozen cycle.
  assert_line_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(line));

endmodule

// File: rtl/sdmp_wr_path.sv
module sdmp_wr_path
  import sdmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wr_beat,
  input  logic dqm_req,
  output logic dq_oe,
  output logic wr_mask
);

  logic oe_hold_q;
  logic mask_hold_q;
  logic oe_live;
  logic mask_live;

  assign oe_live   = wr_beat;
  assign mask_live = wr_masked(wr_beat, dqm_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hold_q   <= 1'b0;
      mask_hold_q <= 1'b0;
    end else if (active) begin
      oe_hold_q   <= oe_live;
      mask_hold_q <= mask_live;
    end
  end

  assign dq_oe   = active ? oe_live   : oe_hold_q;
  assign wr_mask = active ? mask_live : mask_hold_q;

  // A mask strobe only ever accompanies a driven write beat.
  assert_mask_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |-> dq_oe);

  // Consecutive frozen cycles keep the stretched write levels.
  assert_stretch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (active || ($stable(dq_oe) && $stable(wr_mask))));

endmodule

// File: rtl/sdmp_beat_ctr.sv
module sdmp_beat_ctr
  import sdmp_pkg::*;
#(
  parameter int BURST_LEN = 4,
  localparam int POS_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [POS_W-1:0] pos
);

  logic [31:0] pos_wide;
  assign pos_wide = {{(32-POS_W){1'b0}}, pos};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= POS_W'(wrap_inc(pos_wide, 32'(BURST_LEN)));
  end

  assert_pos_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pos_wide < 32'(BURST_LEN));

  assert_pos_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos));

  assert_pos_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pos != $past(pos)));

endmodule

// File: rtl/sdram_mask_suspend.sv
module sdram_mask_suspend
  import sdmp_pkg::*;
#(
  parameter int CAS_LAT   = 2,   // 2, 3 or 4
  parameter int BURST_LEN = 4,
  localparam int POS_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_beat,
  input  logic             wr_beat,
  input  logic             dqm_req,
  input  logic             susp_req,
  output logic             cke_out,
  output logic             dq_oe,
  output logic             wr_mask,
  output logic             rd_valid,
  output logic [POS_W-1:0] burst_pos
);

  logic active;
  logic rd_due;
  logic rd_blank;
  logic beat_step;

  sdmp_cke_ctrl u_cke (
    .clk      (clk),
    .rst_n    (rst_n),
    .susp_req (susp_req),
    .cke_q    (cke_out),
    .active   (active)
  );

  // Read-latency line: a slot travels CAS_LAT active cycles.
  sdmp_hold_shift #(.DEPTH(CAS_LAT)) u_rd_line (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (active),
    .din   (rd_beat & active),
    .dout  (rd_due)
  );

  // Mask history for reads: blanking lands two active cycles later.
  sdmp_hold_shift #(.DEPTH(int'(DQM_RD_LAT))) u_dqm_line (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (active),
    .din   (dqm_req & active),
    .dout  (rd_blank)
  );

  sdmp_wr_path u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .wr_beat (wr_beat),
    .dqm_req (dqm_req),
    .dq_oe   (dq_oe),
    .wr_mask (wr_mask)
  );

  assign beat_step = active & (rd_beat | wr_beat);

  sdmp_beat_ctr #(.BURST_LEN(BURST_LEN)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (beat_step),
    .pos   (burst_pos)
  );

  assign rd_valid = slot_live(rd_due, rd_blank, active);

  // No read slot is reported while the memory clock is suspended.
  assert_valid_needs_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> cke_out);

  // A live read slot never coincides with a blanked one.
  assert_valid_not_blanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_due && !rd_blank));

endmodule

// File: tb/sdram_mask_suspend_tb.sv
module sdram_mask_suspend_tb;

  localparam int CL = 2;
  localparam int BL = 4;
  localparam int PW = $clog2(BL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_beat = 1'b0, wr_beat = 1'b0, dqm_req = 1'b0, susp_req = 1'b0;
  logic cke_out, dq_oe, wr_mask, rd_valid;
  logic [PW-1:0] burst_pos;

  int tests = 0;
  int fails = 0;
  int exp_pos = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_mask_suspend #(.CAS_LAT(CL), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_beat(rd_beat), .wr_beat(wr_beat),
    .dqm_req(dqm_req), .susp_req(susp_req), .cke_out(cke_out),
    .dq_oe(dq_oe), .wr_mask(wr_mask), .rd_valid(rd_valid), .burst_pos(burst_pos)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drives n cycles; bit i of each vector belongs to cycle i.
  task automatic run_seq(input string tag, input int n,
                         input logic [31:0] rd, input logic [31:0] wr,
                         input logic [31:0] dq, input logic [31:0] sp,
                         input logic [31:0] ev, input logic [31:0] eo,
                         input logic [31:0] em, input logic [31:0] ec);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_beat = rd[i]; wr_beat = wr[i]; dqm_req = dq[i]; susp_req = sp[i];
      #1;
      chk("R1", $sformatf("%s cke c%0d", tag, i), int'(cke_out), int'(ec[i]));
      chk(tag, $sformatf("rd_valid c%0d", i), int'(rd_valid), int'(ev[i]));
      chk(tag, $sformatf("dq_oe c%0d", i), int'(dq_oe), int'(eo[i]));
      chk(tag, $sformatf("wr_mask c%0d", i), int'(wr_mask), int'(em[i]));
      chk("R7", $sformatf("%s burst_pos c%0d", tag, i), int'(burst_pos), exp_pos);
      if (ec[i] && (rd[i] || wr[i])) exp_pos = (exp_pos + 1) % BL;
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; susp_req = 1'b1; rd_beat = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "cke in reset", int'(cke_out), 1);
    chk("R9", "burst_pos in reset", int'(burst_pos), 0);
    chk("R9", "rd_valid in reset", int'(rd_valid), 0);
    @(negedge clk);
    susp_req = 1'b0; rd_beat = 1'b0; rst_n = 1'b1;
    exp_pos = 0;
    #1;
    chk("R9", "cke after release", int'(cke_out), 1);
  endtask

  task automatic test_read_plain();   // R2
    run_seq("R2", 8, 32'h0F, 0, 0, 0, 32'h3C, 0, 0, 32'hFF);
  endtask

  task automatic test_read_mask();    // R3
    run_seq("R3", 8, 32'h0F, 0, 32'h0A, 0, 32'h14, 0, 0, 32'hFF);
    run_seq("R3", 8, 32'h11, 0, 32'h01, 0, 32'h40, 0, 0, 32'hFF);
  endtask

  task automatic test_write_mask();   // R4
    run_seq("R4", 8, 0, 32'h0F, 32'h26, 0, 0, 32'h0F, 32'h06, 32'hFF);
  endtask

  task automatic test_read_suspend(); // R5
    run_seq("R5", 10, 32'h03, 0, 0, 32'h0E, 32'h60, 0, 0, 32'h3E3);
    run_seq("R5", 10, 32'h03, 0, 32'h02, 32'h0E, 32'h20, 0, 0, 32'h3E3);
  endtask

  task automatic test_frozen_inputs(); // R8
    run_seq("R8", 10, 32'h03, 0, 32'h08, 32'h0E, 32'h60, 0, 0, 32'h3E3);
    run_seq("R8", 8, 32'h06, 0, 0, 32'h03, 0, 0, 0, 32'hF9);
    run_seq("R8", 8, 0, 32'h06, 32'h06, 32'h03, 0, 0, 0, 32'hF9);
  endtask

  task automatic test_write_stretch(); // R6
    run_seq("R6", 8, 0, 32'h01, 32'h01, 32'h03, 0, 32'h07, 32'h07, 32'hF9);
  endtask

  task automatic test_burst_wrap();    // R7
    run_seq("R7", 12, 32'h0A5, 32'h50A, 0, 0, 32'h294, 32'h50A, 0, 32'hFFF);
  endtask

  initial begin
    test_reset();
    test_read_plain();
    test_read_mask();
    test_write_mask();
    test_read_suspend();
    test_frozen_inputs();
    test_write_stretch();
    test_burst_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule